// File: doc/BRIEF.md
# Sponge Absorb Block Loader with Automatic Padding

This block is the input stage of an extendable-output sponge hash engine. It accepts a message command (a length in bits and a variant select), then takes the message itself as a stream of 64-bit words. It packs the words into rate-sized blocks of 64-bit lanes. The rate is 21 lanes for the 128-bit-security variant and 17 lanes for the 256-bit-security variant, and it is chosen again for each message. After the last message byte the block writes the domain-separation byte and the 10*1 pad pattern, then fills the rest of the block with zeros. If the pad does not fit in the current block, it continues into another block.

Each completed block goes to the permutation stage over a block handshake, together with the variant that was in use and a final-block flag. The block register is freed as soon as the permutation stage takes the block, so the next block of the same message, or the first block of the next message, can be assembled while the permutation is still running.

Back-pressure rules:
- A command is taken only while the loader is idle.
- A data word is taken only while the loader is filling a lane that still holds message bytes.
- A completed block stays on the outputs, unchanged, until `blk_ready` accepts it.
- While a block is waiting, no words are taken.

Top module: `shake_pad_loader`

## Requirements
- R1: `cmd_mode` = 0 selects a rate of 21 lanes and `cmd_mode` = 1 selects 17 lanes. `blk_mode` repeats the selection with each block. For `cmd_mode` = 1, lanes 17 to 20 of `blk_data` are zero.
- R2: `cmd_ready` is high only when no message is in progress and no block is waiting. A command is accepted when `cmd_valid` and `cmd_ready` are both high, and it captures `cmd_mode` and `cmd_len_bits`. The length must be a whole number of bytes.
- R3: Message byte j (0-based) sits at bits [8*(j mod 8)+7 : 8*(j mod 8)] of lane (j div 8) mod rate, in block (j div 8) div rate. Data word w carries message bytes 8w to 8w+7, least significant byte first.
- R4: The byte at message position L, where L is the length in bytes, is 0x1F. Input bytes at or beyond position L in the last data word have no effect on `blk_data`.
- R5: In the final block, bit 63 of lane rate-1 is set. When that lane is also where byte L falls at byte 7, the byte reads 0x9F.
- R6: A message whose length is a whole multiple of the rate produces one extra block that holds only padding. A zero-length message produces exactly one padding-only block and takes no data word.
- R7: Every byte after position L and below the block end is zero, except the final 0x80 bit.
- R8: `blk_valid` rises only once all rate lanes of a block are written. `blk_data`, `blk_mode` and `blk_last` then hold stable until `blk_ready`. `in_ready` is low while `blk_valid` is high.
- R9: `blk_last` is high only with the final block of a message. After that block is accepted, `cmd_ready` is high on the next cycle.
- R10: Exactly ceil(L/8) data words are taken per message. `in_ready` stays low after the last one until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Message command offered |
| cmd_ready | output | 1 | Loader idle, command accepted |
| cmd_mode | input | 1 | 0: 21-lane rate, 1: 17-lane rate |
| cmd_len_bits | input | LEN_W (32) | Message length in bits, byte multiple |
| in_valid | input | 1 | Message word offered |
| in_ready | output | 1 | Message word accepted |
| in_data | input | 64 | Message word, first byte in bits 7:0 |
| blk_valid | output | 1 | Completed padded block available |
| blk_ready | input | 1 | Permutation stage takes the block |
| blk_data | output | 1344 | Block, lane i at bits 64i+63:64i |
| blk_mode | output | 1 | Variant of the block's message |
| blk_last | output | 1 | Final block of the message |

## Verification
A wrong byte counter or a wrong pad flag shows up directly in the block contents. The 0x1F byte lands in the wrong byte or lane, stray data appears where zeros belong, or the 0x80 bit is missing from the final block. Each of these is visible in the first block handed over after the fault. A wrong lane index or rate selection changes when `blk_valid` rises, and therefore how many words are taken. This shows up as a miscounted word stream, or as `in_ready` staying high after the last word, within the same message. A wrong final flag shows at the ports as a missing or extra block, or as `cmd_ready` failing to return one cycle after the final block is accepted.

// File: rtl/shake_pkg.sv
package shake_pkg;
  localparam int LANE_W     = 64;
  localparam int LANE_BYTES = LANE_W / 8;
  localparam int LANES_128  = 21;
  localparam int LANES_256  = 17;
  localparam int MAX_LANES  = LANES_128;
  localparam int IDX_W      = $clog2(MAX_LANES);

  localparam logic [7:0] DSEP_BYTE = 8'h1F;
  localparam logic [7:0] END_BYTE  = 8'h80;

  typedef enum logic {
    MODE_128 = 1'b0,
    MODE_256 = 1'b1
  } shake_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_HOLD = 2'd2
  } ldr_state_e;

  function automatic logic [IDX_W-1:0] last_lane(input shake_mode_e m);
    return (m == MODE_256) ? IDX_W'(LANES_256 - 1) : IDX_W'(LANES_128 - 1);
  endfunction
endpackage

// File: rtl/shake_lane_former.sv
module shake_lane_former
  import shake_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic [LANE_W-1:0] word_i,
  input  logic [CNT_W-1:0]  bytes_left_i,
  input  logic              pad_done_i,
  input  logic              last_lane_i,
  output logic [LANE_W-1:0] lane_o,
  output logic              pad_here_o,
  output logic              close_o
);
  logic short_word;

  assign short_word = bytes_left_i < CNT_W'(LANE_BYTES);
  assign pad_here_o = !pad_done_i && short_word;
  assign close_o    = last_lane_i && (pad_done_i || pad_here_o);

  for (genvar k = 0; k < LANE_BYTES; k++) begin : g_byte
    logic [7:0] b;
    always_comb begin
      if (pad_done_i) begin
        b = '0;
      end else if (!short_word || (CNT_W'(k) < bytes_left_i)) begin
        b = word_i[8*k +: 8];
      end else if (CNT_W'(k) == bytes_left_i) begin
        b = DSEP_BYTE;
      end else begin
        b = '0;
      end
    end
    if (k == LANE_BYTES - 1) begin : g_top
      assign lane_o[8*k +: 8] = close_o ? (b | END_BYTE) : b;
    end else begin : g_low
      assign lane_o[8*k +: 8] = b;
    end
  end
endmodule

// File: rtl/shake_lane_buffer.sv
module shake_lane_buffer
  import shake_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [LANE_W-1:0]           wr_lane_i,
  input  shake_mode_e                 mode_i,
  output logic [MAX_LANES*LANE_W-1:0] data_o
);
  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        q <= wr_lane_i;
      end
    end
    if (i >= LANES_256) begin : g_hi
      assign data_o[i*LANE_W +: LANE_W] = (mode_i == MODE_256) ? '0 : q;
    end else begin : g_lo
      assign data_o[i*LANE_W +: LANE_W] = q;
    end
  end
endmodule

// File: rtl/shake_loader_ctrl.sv
module shake_loader_ctrl
  import shake_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid_i,
  input  shake_mode_e        cmd_mode_i,
  input  logic [CNT_W-1:0]   cmd_bytes_i,
  input  logic               in_valid_i,
  input  logic               blk_ready_i,
  input  logic               pad_here_i,
  input  logic               close_i,
  output logic               cmd_ready_o,
  output logic               in_ready_o,
  output logic               blk_valid_o,
  output logic               blk_last_o,
  output shake_mode_e        mode_o,
  output logic [CNT_W-1:0]   bytes_left_o,
  output logic               pad_done_o,
  output logic [IDX_W-1:0]   lane_idx_o,
  output logic               last_lane_o,
  output logic               wr_en_o
);
  ldr_state_e       state_q;
  shake_mode_e      mode_q;
  logic [CNT_W-1:0] left_q;
  logic             pad_q;
  logic             last_q;
  logic [IDX_W-1:0] idx_q;
  logic             need_input;
  logic             advance;

  assign need_input  = !pad_q && (left_q != '0);
  assign advance     = (state_q == ST_FILL) && (!need_input || in_valid_i);
  assign last_lane_o = idx_q == last_lane(mode_q);

  assign cmd_ready_o  = state_q == ST_IDLE;
  assign in_ready_o   = (state_q == ST_FILL) && need_input;
  assign blk_valid_o  = state_q == ST_HOLD;
  assign blk_last_o   = (state_q == ST_HOLD) && last_q;
  assign mode_o       = mode_q;
  assign bytes_left_o = left_q;
  assign pad_done_o   = pad_q;
  assign lane_idx_o   = idx_q;
  assign wr_en_o      = advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_128;
      left_q  <= '0;
      pad_q   <= 1'b0;
      last_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            mode_q  <= cmd_mode_i;
            left_q  <= cmd_bytes_i;
            pad_q   <= 1'b0;
            last_q  <= 1'b0;
            idx_q   <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (advance) begin
            left_q <= (left_q >= CNT_W'(LANE_BYTES)) ? left_q - CNT_W'(LANE_BYTES) : '0;
            if (pad_here_i) pad_q <= 1'b1;
            if (last_lane_o) begin
              last_q  <= close_i;
              state_q <= ST_HOLD;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (blk_ready_i) begin
            idx_q   <= '0;
            state_q <= last_q ? ST_IDLE : ST_FILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shake_pad_loader.sv
module shake_pad_loader
  import shake_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic                        cmd_mode,
  input  logic [LEN_W-1:0]            cmd_len_bits,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANE_W-1:0]           in_data,
  output logic                        blk_valid,
  input  logic                        blk_ready,
  output logic [MAX_LANES*LANE_W-1:0] blk_data,
  output logic                        blk_mode,
  output logic                        blk_last
);
  localparam int CNT_W = LEN_W - 3;

  shake_mode_e      mode;
  logic [CNT_W-1:0] bytes_left;
  logic             pad_done;
  logic [IDX_W-1:0] lane_idx;
  logic             last_lane;
  logic             wr_en;
  logic             pad_here;
  logic             close;
  logic [LANE_W-1:0] lane;

  shake_loader_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_mode_i   (shake_mode_e'(cmd_mode)),
    .cmd_bytes_i  (cmd_len_bits[LEN_W-1:3]),
    .in_valid_i   (in_valid),
    .blk_ready_i  (blk_ready),
    .pad_here_i   (pad_here),
    .close_i      (close),
    .cmd_ready_o  (cmd_ready),
    .in_ready_o   (in_ready),
    .blk_valid_o  (blk_valid),
    .blk_last_o   (blk_last),
    .mode_o       (mode),
    .bytes_left_o (bytes_left),
    .pad_done_o   (pad_done),
    .lane_idx_o   (lane_idx),
    .last_lane_o  (last_lane),
    .wr_en_o      (wr_en)
  );

  shake_lane_former #(.CNT_W(CNT_W)) u_former (
    .word_i       (in_data),
    .bytes_left_i (bytes_left),
    .pad_done_i   (pad_done),
    .last_lane_i  (last_lane),
    .lane_o       (lane),
    .pad_here_o   (pad_here),
    .close_o      (close)
  );

  shake_lane_buffer u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (lane_idx),
    .wr_lane_i (lane),
    .mode_i    (mode),
    .data_o    (blk_data)
  );

  assign blk_mode = mode;
endmodule

// File: rtl/shake_pad_loader_chk.sv
module shake_pad_loader_chk #(
  parameter int DW = 1344
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          in_ready,
  input logic          blk_valid,
  input logic          blk_ready,
  input logic [DW-1:0] blk_data,
  input logic          blk_mode,
  input logic          blk_last
);
  localparam int LO_TOP = 17 * 64;
  localparam int HI_TOP = 21 * 64;

  // R8
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_last) && $stable(blk_mode));

  // R8
  no_input_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !in_ready);

  // R2
  cmd_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !blk_valid && !in_ready);

  // R5
  final_pad_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_last |-> (blk_mode ? blk_data[LO_TOP-1] : blk_data[HI_TOP-1]));

  // R1
  short_rate_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_mode |-> blk_data[HI_TOP-1:LO_TOP] == '0);

  // R9
  idle_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready && blk_last |=> cmd_ready);
endmodule

bind shake_pad_loader shake_pad_loader_chk #(.DW(shake_pkg::MAX_LANES * shake_pkg::LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .in_ready  (in_ready),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .blk_data  (blk_data),
  .blk_mode  (blk_mode),
  .blk_last  (blk_last)
);

// File: tb/shake_pad_loader_tb.sv
module shake_pad_loader_tb;
  localparam int LW    = 64;
  localparam int ML    = 21;
  localparam int DW    = ML * LW;
  localparam int LEN_W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          cmd_valid, cmd_ready, cmd_mode;
  logic [LEN_W-1:0] cmd_len_bits;
  logic          in_valid, in_ready;
  logic [LW-1:0] in_data;
  logic          blk_valid, blk_ready, blk_mode, blk_last;
  logic [DW-1:0] blk_data;

  shake_pad_loader #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode), .cmd_len_bits(cmd_len_bits),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .blk_mode(blk_mode), .blk_last(blk_last)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] msg [0:1023];
  logic [7:0] expb[0:1023];
  int  cur_len, cur_rate, cur_blocks;
  logic cur_mode;
  bit  msg_done;
  int  words_taken;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic build_expected();
    int rb = cur_rate * 8;
    int total;
    cur_blocks = cur_len / rb + 1;
    total = cur_blocks * rb;
    for (int i = 0; i < total; i++) expb[i] = (i < cur_len) ? msg[i] : 8'h00;
    expb[cur_len] = 8'h1F;
    expb[total-1] = expb[total-1] | 8'h80;
  endtask

  function automatic logic [LW-1:0] word_of(input int w);
    logic [LW-1:0] v;
    for (int k = 0; k < 8; k++)
      v[8*k +: 8] = (8*w + k < cur_len) ? msg[8*w + k] : 8'($urandom);
    return v;
  endfunction

  task automatic producer();
    int nwords = (cur_len + 7) / 8;
    bit acc;
    @(negedge clk);
    cmd_valid    = 1'b1;
    cmd_mode     = cur_mode;
    cmd_len_bits = LEN_W'(cur_len * 8);
    do begin
      #1 acc = cmd_ready;
      if (!acc) @(negedge clk);
    end while (!acc);
    @(negedge clk);
    cmd_valid = 1'b0;
    words_taken = 0;
    while (words_taken < nwords) begin
      in_valid = ($urandom % 4) != 0;
      in_data  = word_of(words_taken);
      #1;
      if (in_valid && in_ready) words_taken++;
      @(negedge clk);
    end
    while (!msg_done) begin
      in_valid = 1'b1;
      in_data  = {$urandom, $urandom};
      #1;
      // R10: no further words are taken
      chk(!in_ready, "R10", "in_ready after last word", LW'(in_ready), 64'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic consumer();
    int b = 0;
    bit pending = 1'b0;
    logic [DW-1:0] held;
    logic          held_last;
    logic [LW-1:0] el, al;
    while (b < cur_blocks) begin
      @(negedge clk);
      blk_ready = ($urandom % 3) != 0;
      #1;
      if (blk_valid) begin
        // R8: stable while waiting, no input taken
        if (pending)
          chk(held == blk_data && held_last == blk_last, "R8", "block held stable",
              LW'(blk_last), LW'(held_last));
        chk(!in_ready, "R8", "in_ready while block waits", LW'(in_ready), 64'd0);
        if (blk_ready) begin
          for (int i = 0; i < ML; i++) begin
            for (int k = 0; k < 8; k++)
              el[8*k +: 8] = (i < cur_rate) ? expb[(b*cur_rate + i)*8 + k] : 8'h00;
            al = blk_data[i*LW +: LW];
            // R1 R3 R4 R5 R6 R7: lane contents
            chk(al == el, "R1/R3/R4/R5/R7", $sformatf("block %0d lane %0d", b, i), al, el);
          end
          // R9: final flag only on last block
          chk(blk_last == (b == cur_blocks - 1), "R9", $sformatf("blk_last block %0d", b),
              LW'(blk_last), LW'(b == cur_blocks - 1));
          // R1: mode echoed
          chk(blk_mode == cur_mode, "R1", "blk_mode", LW'(blk_mode), LW'(cur_mode));
          b++;
          pending = 1'b0;
        end else begin
          pending   = 1'b1;
          held      = blk_data;
          held_last = blk_last;
        end
      end
    end
    msg_done = 1'b1;
    @(negedge clk);
    blk_ready = 1'b0;
    #1;
    // R9 R2: idle again one cycle after final acceptance
    chk(cmd_ready, "R9", "cmd_ready after final block", LW'(cmd_ready), 64'd1);
    // R6 R10: word count
    chk(words_taken == (cur_len + 7) / 8, "R10", "words taken",
        LW'(words_taken), LW'((cur_len + 7) / 8));
  endtask

  task automatic run_msg(input logic m, input int len);
    cur_mode = m;
    cur_len  = len;
    cur_rate = m ? 17 : 21;
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
    build_expected();
    msg_done = 1'b0;
    fork
      producer();
      consumer();
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24601));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = 1'b0; cmd_len_bits = '0;
    in_valid = 1'b0; in_data = '0; blk_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R2 R8: reset state
    chk(cmd_ready && !blk_valid && !in_ready, "R2", "reset state",
        {61'd0, cmd_ready, blk_valid, in_ready}, 64'd4);
    // R6: zero-length messages, both rates
    run_msg(1'b0, 0);
    run_msg(1'b1, 0);
    // R6: exact rate multiples
    run_msg(1'b0, 168);
    run_msg(1'b1, 136);
    run_msg(1'b0, 336);
    // R5: 0x9F coincidence
    run_msg(1'b0, 167);
    run_msg(1'b1, 135);
    // R4: short and partial words
    run_msg(1'b0, 5);
    run_msg(1'b1, 8);
    run_msg(1'b1, 141);
    for (int n = 0; n < 25; n++) run_msg(1'($urandom), int'($urandom % 401));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule